// File: doc/BRIEF.md
# Serial Management Frame Slave

This block is the device-side end of a two-wire serial management link. It runs directly on the management clock and samples the data line on every rising edge. It waits for a run of at least 32 ones, then decodes a start code, an opcode, a 5-bit device address and a 5-bit register address. A frame is acted on only when the device address equals the value on five static strap inputs.

A matching write frame ends with a one-cycle write strobe, together with the register address and the 16-bit data word. A matching read frame works differently. The block captures a word from the attached register bank through a parallel read port. It drives the turnaround and data bits back onto the line through an output enable, then raises a one-cycle read-done pulse. The bank can use that pulse for clear-on-read side effects.

If a frame has a bad start code, an unknown opcode or a foreign address, the block leaves the line released and hunts for a fresh preamble.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `mdioOe`, `regWrEn` and `regRdDone` are all 0.
- R2: A frame is decoded only when the start code 0 then 1 directly follows at least 32 consecutive 1 bits sampled on the line. A frame with a shorter preamble, or whose start bits are not 0 then 1, causes no strobe and leaves the line undriven.
- R3: The opcode is the 2 bits after the start code. The value 1 then 0 means read and 0 then 1 means write. The values 00 and 11 cause no strobe and no drive.
- R4: The 5-bit device address, sent MSB first after the opcode, must equal `phyAddrStrap`. On a mismatch there is no strobe and no drive.
- R5: For a matching write, the cycle after the edge that samples the 16th data bit has `regWrEn` high for exactly one cycle. In that cycle `regAddr` holds the register address and `regWrData` holds the data word, both received MSB first.
- R6: For a matching read, the line stays released during the first turnaround bit. After the edge that samples that bit, `mdioOe` is 1 and `mdioOut` is 0.
- R7: For a matching read, `regRdData` is captured at the edge that samples the second turnaround bit. Its 16 bits appear on `mdioOut` MSB first, each one changing just after a rising edge. The enable drops after the edge that samples the last data bit.
- R8: For a matching read, `regRdDone` is high for exactly one cycle after the last data bit, and `regAddr` then holds the register that was read.
- R9: After any frame ends or is abandoned, the next frame needs its own preamble of at least 32 ones. A frame sent straight after a 0 bit with no preamble is ignored.
- R10: `mdioOe` is high only from the second turnaround bit through the last data bit of a matching read. It is never high during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdcClk | input | 1 | Management clock; the line is sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| mdioIn | input | 1 | Line value as seen by the slave |
| mdioOut | output | 1 | Value driven onto the line; 0 when released |
| mdioOe | output | 1 | Tristate enable for the line driver |
| phyAddrStrap | input | 5 | Static device address to match |
| regAddr | output | 5 | Register address of the current frame |
| regWrData | output | 16 | Write data, valid with `regWrEn` |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdData | input | 16 | Read word from the bank for `regAddr` |
| regRdDone | output | 1 | One-cycle pulse after a read frame completes |

## Verification
The bench probes the preamble at 31 ones, at exactly 32 ones, at 40 ones and with no preamble at all after a 0 bit. A counter that is off by one, or that is not cleared when a frame ends, would answer a frame that must be ignored. Frames with the opcodes 00 and 11, a start code of 00, and addresses that differ from the strap (including after the strap changes) must leave both the line and the bank alone. A design that drove anyway would show a stray enable or corrupt a register that a later read returns.

On matching reads the line is compared bit by bit against the bench's register model, with all-ones and all-zero words as boundary patterns. This catches a turnaround bit that is driven one cycle early or late, and a data field that is shifted by one position.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_OP,
    ST_ADDR,
    ST_TURN,
    ST_DATA
  } frameState_e;

  typedef struct packed {
    logic shiftIn;
    logic captureAddr;
    logic driveZero;
    logic loadRd;
    logic shiftOut;
    logic finishWr;
    logic finishRd;
  } dpCtrl_t;

endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    mdioIn,
  input  logic    addrHit,
  output dpCtrl_t ctrl
);

  localparam int ADDR_BITS = 2 * AW;
  localparam int CNT_MAX   = (DW > ADDR_BITS) ? DW : ADDR_BITS;
  localparam int CW        = $clog2(CNT_MAX);
  localparam int PCW       = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0]  ADDR_LAST = CW'(ADDR_BITS - 1);
  localparam logic [CW-1:0]  DATA_LAST = CW'(DW - 1);
  localparam logic [PCW-1:0] PRE_FULL  = PCW'(PRE_LEN);

  frameState_e    state;
  logic [PCW-1:0] oneCnt;
  logic [CW-1:0]  bitCnt;
  logic           opFirst;
  logic           isRead;

  logic lastAddrBit;
  logic lastDataBit;

  assign lastAddrBit = (state == ST_ADDR) && (bitCnt == ADDR_LAST);
  assign lastDataBit = (state == ST_DATA) && (bitCnt == DATA_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      oneCnt  <= '0;
      bitCnt  <= '0;
      opFirst <= 1'b0;
      isRead  <= 1'b0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (mdioIn) begin
            if (oneCnt != PRE_FULL) oneCnt <= oneCnt + 1'b1;
          end else begin
            oneCnt <= '0;
            if (oneCnt == PRE_FULL) state <= ST_START;
          end
        end
        ST_START: begin
          bitCnt <= '0;
          state  <= mdioIn ? ST_OP : ST_HUNT;
        end
        ST_OP: begin
          if (bitCnt == '0) begin
            opFirst <= mdioIn;
            bitCnt  <= bitCnt + 1'b1;
          end else begin
            bitCnt <= '0;
            if (opFirst ^ mdioIn) begin
              isRead <= opFirst;
              state  <= ST_ADDR;
            end else begin
              state <= ST_HUNT;
            end
          end
        end
        ST_ADDR: begin
          if (lastAddrBit) begin
            bitCnt <= '0;
            state  <= addrHit ? ST_TURN : ST_HUNT;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_TURN: begin
          if (bitCnt == CW'(1)) begin
            bitCnt <= '0;
            state  <= ST_DATA;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (lastDataBit) begin
            bitCnt <= '0;
            state  <= ST_HUNT;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    ctrl             = '0;
    ctrl.shiftIn     = (state == ST_ADDR) || ((state == ST_DATA) && !isRead);
    ctrl.captureAddr = lastAddrBit && addrHit;
    ctrl.driveZero   = (state == ST_TURN) && (bitCnt == '0) && isRead;
    ctrl.loadRd      = (state == ST_TURN) && (bitCnt == CW'(1)) && isRead;
    ctrl.shiftOut    = (state == ST_DATA) && isRead && !lastDataBit;
    ctrl.finishWr    = lastDataBit && !isRead;
    ctrl.finishRd    = lastDataBit && isRead;
  end

  AST_START_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START) |-> !$past(mdioIn)); // R2

  AST_TURN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_TURN) && (bitCnt == '0)) |-> $past(addrHit)); // R4

  AST_HUNT_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    lastDataBit |=> ((state == ST_HUNT) && (oneCnt == '0))); // R9

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.captureAddr, ctrl.driveZero, ctrl.loadRd, ctrl.finishWr, ctrl.finishRd})); // R5

endmodule

// File: rtl/mdio_frame_dp.sv
module mdio_frame_dp
  import mdio_slave_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          mdioIn,
  input  dpCtrl_t       ctrl,
  input  logic [AW-1:0] phyAddrStrap,
  input  logic [DW-1:0] regRdData,
  output logic          addrHit,
  output logic          mdioOut,
  output logic          mdioOe,
  output logic [AW-1:0] regAddr,
  output logic [DW-1:0] regWrData,
  output logic          regWrEn,
  output logic          regRdDone
);

  localparam int PHY_TOP = 2 * AW - 2;

  logic [DW-1:0] shReg;
  logic          outBit;
  logic          oeReg;

  // the device address occupies the upper half of the last 2*AW bits
  assign addrHit = (shReg[PHY_TOP -: AW] == phyAddrStrap);
  assign mdioOut = oeReg & outBit;
  assign mdioOe  = oeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (ctrl.shiftIn) begin
      shReg <= {shReg[DW-2:0], mdioIn};
    end else if (ctrl.loadRd) begin
      shReg <= {regRdData[DW-2:0], 1'b0};
    end else if (ctrl.shiftOut) begin
      shReg <= {shReg[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBit <= 1'b0;
      oeReg  <= 1'b0;
    end else begin
      if (ctrl.driveZero) begin
        outBit <= 1'b0;
        oeReg  <= 1'b1;
      end else if (ctrl.loadRd) begin
        outBit <= regRdData[DW-1];
      end else if (ctrl.shiftOut) begin
        outBit <= shReg[DW-1];
      end else if (ctrl.finishRd) begin
        outBit <= 1'b0;
        oeReg  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddr   <= '0;
      regWrData <= '0;
      regWrEn   <= 1'b0;
      regRdDone <= 1'b0;
    end else begin
      regWrEn   <= ctrl.finishWr;
      regRdDone <= ctrl.finishRd;
      if (ctrl.captureAddr) regAddr <= {shReg[AW-2:0], mdioIn};
      if (ctrl.finishWr) regWrData <= {shReg[DW-2:0], mdioIn};
    end
  end

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R5

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regRdDone |=> !regRdDone); // R8

  AST_TA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.driveZero |=> (mdioOe && !mdioOut)); // R6

  AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    regRdDone |-> !mdioOe); // R7

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !mdioOe); // R10

  AST_OE_ONLY_FROM_TURN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> $past(ctrl.driveZero)); // R10

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic          mdcClk,
  input  logic          rstN,
  input  logic          mdioIn,
  output logic          mdioOut,
  output logic          mdioOe,
  input  logic [AW-1:0] phyAddrStrap,
  output logic [AW-1:0] regAddr,
  output logic [DW-1:0] regWrData,
  output logic          regWrEn,
  input  logic [DW-1:0] regRdData,
  output logic          regRdDone
);

  dpCtrl_t ctrl;
  logic    addrHit;

  mdio_frame_ctrl #(
    .PRE_LEN(PRE_LEN),
    .AW     (AW),
    .DW     (DW)
  ) u_ctrl (
    .clk    (mdcClk),
    .rstN   (rstN),
    .mdioIn (mdioIn),
    .addrHit(addrHit),
    .ctrl   (ctrl)
  );

  mdio_frame_dp #(
    .AW(AW),
    .DW(DW)
  ) u_dp (
    .clk         (mdcClk),
    .rstN        (rstN),
    .mdioIn      (mdioIn),
    .ctrl        (ctrl),
    .phyAddrStrap(phyAddrStrap),
    .regRdData   (regRdData),
    .addrHit     (addrHit),
    .mdioOut     (mdioOut),
    .mdioOe      (mdioOe),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regWrEn     (regWrEn),
    .regRdDone   (regRdDone)
  );

endmodule

// File: tb/sim_mdio_mgmt_slave.sv
module sim_mdio_mgmt_slave;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic        mDrv;
  logic        mBit;
  logic [4:0]  strap;
  logic        mdioOut, mdioOe;
  logic [4:0]  regAddr;
  logic [15:0] regWrData, regRdData;
  logic        regWrEn, regRdDone;
  logic        mdioLine;

  logic [15:0] bank  [32];
  logic [15:0] model [32];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // open-drain style line with pull-up: slave, else master, else 1
  assign mdioLine  = mdioOe ? mdioOut : (mDrv ? mBit : 1'b1);
  assign regRdData = bank[regAddr];

  always @(posedge clk) if (regWrEn) bank[regAddr] <= regWrData;

  mdio_mgmt_slave u0 (
    .mdcClk      (clk),
    .rstN        (rstN),
    .mdioIn      (mdioLine),
    .mdioOut     (mdioOut),
    .mdioOe      (mdioOe),
    .phyAddrStrap(strap),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regWrEn     (regWrEn),
    .regRdData   (regRdData),
    .regRdDone   (regRdDone)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one bit time: drive after falling edge, compare just after rising edge
  task automatic sendBit(bit drv, bit v, bit eOe, bit eOut, bit eWr, bit eRd, string tag);
    @(negedge clk);
    mDrv = drv;
    mBit = v;
    @(posedge clk);
    #1;
    chk(tag, "mdioOe", 32'(mdioOe), 32'(eOe));
    if (eOe) chk(tag, "mdioOut", 32'(mdioOut), 32'(eOut));
    chk(tag, "regWrEn", 32'(regWrEn), 32'(eWr));
    chk(tag, "regRdDone", 32'(regRdDone), 32'(eRd));
  endtask

  task automatic sendFrame(int preLen, logic [1:0] st, logic [1:0] op,
                           logic [4:0] phy, logic [4:0] ra, logic [15:0] wd);
    bit          accept, isRd, eOe, eOut, eWr, eRd, drv;
    string       tag, rejTag;
    logic [31:0] fr;
    logic [15:0] rdVal;
    isRd   = (op == 2'b10);
    accept = (preLen >= 32) && (st == 2'b01) &&
             (op == 2'b10 || op == 2'b01) && (phy == strap);
    if (preLen == 0)                       rejTag = "R9";
    else if (preLen < 32 || st != 2'b01)   rejTag = "R2";
    else if (op == 2'b00 || op == 2'b11)   rejTag = "R3";
    else                                   rejTag = "R4";
    rdVal = model[ra];
    fr    = {st, op, phy, ra, 2'b10, wd};
    for (int i = 0; i < preLen; i++) sendBit(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    for (int p = 0; p < 32; p++) begin
      drv  = !(op == 2'b10 && p >= 14);
      eOe  = accept && isRd && p >= 14 && p <= 30;
      eOut = (p <= 14) ? 1'b0 : ((p == 15) ? rdVal[15] : rdVal[30-p]);
      eWr  = accept && !isRd && p == 31;
      eRd  = accept && isRd && p == 31;
      if (!accept)      tag = rejTag;
      else if (p < 14)  tag = "R10";
      else if (p == 14) tag = "R6";
      else if (p < 31)  tag = "R7";
      else              tag = isRd ? "R8" : "R5";
      sendBit(drv, fr[31-p], eOe, eOut, eWr, eRd, tag);
    end
    if (accept && !isRd) begin
      chk("R5", "regAddr", 32'(regAddr), 32'(ra));
      chk("R5", "regWrData", 32'(regWrData), 32'(wd));
      model[ra] = wd;
    end
    if (accept && isRd) chk("R8", "regAddr", 32'(regAddr), 32'(ra));
    // pulses must be gone one cycle later
    sendBit(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, accept ? (isRd ? "R8" : "R5") : rejTag);
  endtask

  task automatic idleZero();
    sendBit(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      bank[i]  = 16'(i * 16'h00F1) ^ 16'h5A00;
      model[i] = 16'(i * 16'h00F1) ^ 16'h5A00;
    end
    rstN  = 1'b0;
    mDrv  = 1'b1;
    mBit  = 1'b1;
    strap = 5'h15;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "mdioOe", 32'(mdioOe), 32'd0);
    chk("R1", "regWrEn", 32'(regWrEn), 32'd0);
    chk("R1", "regRdDone", 32'(regRdDone), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    sendBit(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

    // R5 write, R6/R7/R8 read back
    sendFrame(32, 2'b01, 2'b01, 5'h15, 5'd3, 16'hA5C3);
    sendFrame(32, 2'b01, 2'b10, 5'h15, 5'd3, 16'h0000);
    // R4 foreign address, write then read
    sendFrame(32, 2'b01, 2'b01, 5'h14, 5'd3, 16'h1234);
    sendFrame(32, 2'b01, 2'b10, 5'h15, 5'd3, 16'h0000);
    sendFrame(32, 2'b01, 2'b10, 5'h05, 5'd3, 16'h0000);
    // R2 preamble one bit short
    idleZero();
    sendFrame(31, 2'b01, 2'b01, 5'h15, 5'd7, 16'hBEEF);
    sendFrame(40, 2'b01, 2'b10, 5'h15, 5'd7, 16'h0000);
    // R3 invalid opcodes
    sendFrame(32, 2'b01, 2'b11, 5'h15, 5'd7, 16'h4321);
    sendFrame(32, 2'b01, 2'b00, 5'h15, 5'd7, 16'h4321);
    // R2 bad start code
    sendFrame(32, 2'b00, 2'b01, 5'h15, 5'd7, 16'h7777);
    // R9 frame without its own preamble
    idleZero();
    sendFrame(0, 2'b01, 2'b01, 5'h15, 5'd7, 16'h0F0F);
    sendFrame(32, 2'b01, 2'b10, 5'h15, 5'd7, 16'h0000);
    // boundary data patterns
    sendFrame(32, 2'b01, 2'b01, 5'h15, 5'd31, 16'hFFFF);
    sendFrame(32, 2'b01, 2'b10, 5'h15, 5'd31, 16'h0000);
    sendFrame(32, 2'b01, 2'b01, 5'h15, 5'd0, 16'h0000);
    sendFrame(32, 2'b01, 2'b10, 5'h15, 5'd0, 16'h0000);
    sendFrame(32, 2'b01, 2'b10, 5'h15, 5'd16, 16'h0000);
    // R4 after the strap changes
    strap = 5'h0A;
    sendBit(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    sendFrame(32, 2'b01, 2'b01, 5'h0A, 5'd9, 16'h6C39);
    sendFrame(32, 2'b01, 2'b10, 5'h15, 5'd9, 16'h0000);
    sendFrame(32, 2'b01, 2'b10, 5'h0A, 5'd9, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule